// File: doc/BRIEF.md
# Speculative Line Tracker with Snoop Violation

This block holds the per-line speculation state of a small transactional cache: a valid flag, the line address, a read flag and a written flag for every line. While a transaction runs, local loads mark lines as read and local stores mark them as written. The cache data array sits outside this block and follows the tracker's decisions.

A snoop port receives the commit beats that other nodes broadcast. Each beat's address is compared against every local line. If the beat hits a line that the running transaction has read, the block reports a dependence violation. It drops every speculatively written line, wipes all speculation flags, and then ignores further snoops and local accesses until the transaction is restarted. A hit on a line that has not been read either drops the line, for an address-only beat, or raises an update strobe for the data array, for a beat that carries data. When the local transaction commits, all speculation flags are cleared and the written lines stay valid as committed data.

Top module: `slt_tracker`

## Requirements
- R1: After reset, every line is invalid with its read and written flags clear, and `violation`, `wait_restart` and `upd_en` are low.
- R2: A fill makes the addressed line valid with the given line address and clears its read and written flags, one cycle after `fill_en`.
- R3: A local load (`acc_en` high, `acc_wr` low) whose address matches a valid line sets that line's read flag. A read flag is never set on an invalid line.
- R4: A local store (`acc_en` high, `acc_wr` high) whose address matches a valid line sets that line's written flag.
- R5: A snoop beat whose address matches a valid line with its read flag set raises `violation` high for exactly one cycle, in the cycle after the beat.
- R6: On a violation, every line whose written flag was set becomes invalid, lines that were not written stay valid, and all read and written flags are cleared.
- R7: An address-only snoop beat (`snp_has_data` low) that matches a line without its read flag set invalidates that line and clears its flags, without a violation.
- R8: A snoop beat carrying data (`snp_has_data` high) that matches a line without its read flag set leaves the line valid and pulses `upd_en` for one cycle, with `upd_idx` giving the line index.
- R9: A local commit (`commit_done`) clears all read and written flags and leaves every valid line valid. A line that was read before the commit no longer causes a violation.
- R10: While `grant_held` is high, snoop beats have no effect: no violation, no update and no change to line state.
- R11: After a violation, `wait_restart` stays high and snoop beats, local accesses and commits are ignored until `restart` is pulsed. `restart` clears `wait_restart` one cycle later.
- R12: A snoop beat that matches no valid line changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_en | input | 1 | Install a line |
| fill_idx | input | IDX_W | Line index to install |
| fill_addr | input | ADDR_W | Line address to install |
| acc_en | input | 1 | Local speculative access |
| acc_wr | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Line address of the local access |
| grant_held | input | 1 | Local node holds the commit grant |
| commit_done | input | 1 | Local transaction commit completes |
| restart | input | 1 | Transaction restarted after a violation |
| snp_en | input | 1 | Snooped commit beat valid |
| snp_has_data | input | 1 | Beat carries data (update), else address only (invalidate) |
| snp_addr | input | ADDR_W | Line address of the snooped beat |
| line_valid | output | NUM_LINES | Per-line valid flags |
| line_rd | output | NUM_LINES | Per-line speculative read flags |
| line_mod | output | NUM_LINES | Per-line speculative written flags |
| violation | output | 1 | One-cycle dependence violation pulse |
| wait_restart | output | 1 | Violation taken, waiting for restart |
| upd_en | output | 1 | Update strobe for the data array |
| upd_idx | output | IDX_W | Line index to update |

## Verification
The checker watches the properties that hold in every cycle: the violation pulse lasts a single cycle and always follows an active snoop beat, flags are clear when it fires, written lines are gone after it, no pulse or update appears while the grant is held or while the block waits for restart, a commit leaves no flag set, and no read flag sits on an invalid line. The bench scenarios show what depends on a particular history: which exact line is dropped or updated, that lines which were only read stay valid through a violation, that accesses are ignored during the wait, and that a line read before a commit no longer triggers a violation.

// File: rtl/slt_pkg.sv
package slt_pkg;

    // Outcome of one snooped commit beat against the local lines.
    typedef enum logic [1:0] {
        SNP_NONE   = 2'd0,
        SNP_VIOL   = 2'd1,
        SNP_INVAL  = 2'd2,
        SNP_UPDATE = 2'd3
    } snp_kind_e;

endpackage

// File: rtl/slt_tag_match.sv
module slt_tag_match #(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 16
) (
    input  logic [NUM_LINES-1:0][ADDR_W-1:0] tags,
    input  logic [NUM_LINES-1:0]             valid,
    input  logic [ADDR_W-1:0]                addr,
    output logic [NUM_LINES-1:0]             hit
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
        assign hit[g] = valid[g] && (tags[g] == addr);
    end

endmodule

// File: rtl/slt_snoop_eval.sv
module slt_snoop_eval
    import slt_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0] hit,
    input  logic [NUM_LINES-1:0] rd,
    input  logic                 has_data,
    output snp_kind_e            kind,
    output logic [IDX_W-1:0]     idx
);

    always_comb begin
        idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                idx = IDX_W'(i);
            end
        end
        if ((hit & rd) != '0) begin
            kind = SNP_VIOL;
        end else if (hit != '0) begin
            kind = has_data ? SNP_UPDATE : SNP_INVAL;
        end else begin
            kind = SNP_NONE;
        end
    end

endmodule

// File: rtl/slt_tracker.sv
module slt_tracker
    import slt_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 16,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fill_en,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic [ADDR_W-1:0]    fill_addr,
    input  logic                 acc_en,
    input  logic                 acc_wr,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic                 grant_held,
    input  logic                 commit_done,
    input  logic                 restart,
    input  logic                 snp_en,
    input  logic                 snp_has_data,
    input  logic [ADDR_W-1:0]    snp_addr,
    output logic [NUM_LINES-1:0] line_valid,
    output logic [NUM_LINES-1:0] line_rd,
    output logic [NUM_LINES-1:0] line_mod,
    output logic                 violation,
    output logic                 wait_restart,
    output logic                 upd_en,
    output logic [IDX_W-1:0]     upd_idx
);

    typedef struct packed {
        logic [NUM_LINES-1:0]             valid;
        logic [NUM_LINES-1:0]             rd;
        logic [NUM_LINES-1:0]             mod;
        logic [NUM_LINES-1:0][ADDR_W-1:0] tag;
        logic                             wait_rs;
        logic                             viol;
        logic                             upd;
        logic [IDX_W-1:0]                 upd_idx;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_LINES-1:0] acc_hit;
    logic [NUM_LINES-1:0] snp_hit;
    snp_kind_e            snp_kind;
    logic [IDX_W-1:0]     snp_idx;
    logic                 snp_act;

    slt_tag_match #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_acc_match (
        .tags  (st_q.tag),
        .valid (st_q.valid),
        .addr  (acc_addr),
        .hit   (acc_hit)
    );

    slt_tag_match #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_snp_match (
        .tags  (st_q.tag),
        .valid (st_q.valid),
        .addr  (snp_addr),
        .hit   (snp_hit)
    );

    slt_snoop_eval #(.NUM_LINES(NUM_LINES)) u_snp_eval (
        .hit      (snp_hit),
        .rd       (st_q.rd),
        .has_data (snp_has_data),
        .kind     (snp_kind),
        .idx      (snp_idx)
    );

    assign snp_act = snp_en && !grant_held && !st_q.wait_rs;

    always_comb begin
        st_d      = st_q;
        st_d.viol = 1'b0;
        st_d.upd  = 1'b0;

        if (restart) begin
            st_d.wait_rs = 1'b0;
        end

        if (fill_en) begin
            st_d.valid[fill_idx] = 1'b1;
            st_d.rd[fill_idx]    = 1'b0;
            st_d.mod[fill_idx]   = 1'b0;
            st_d.tag[fill_idx]   = fill_addr;
        end

        if (!st_q.wait_rs) begin
            if (commit_done) begin
                st_d.rd  = '0;
                st_d.mod = '0;
            end else if (acc_en) begin
                if (acc_wr) begin
                    st_d.mod = st_d.mod | acc_hit;
                end else begin
                    st_d.rd = st_d.rd | acc_hit;
                end
            end
        end

        if (snp_act) begin
            case (snp_kind)
                SNP_VIOL: begin
                    st_d.valid   = st_d.valid & ~st_d.mod;
                    st_d.rd      = '0;
                    st_d.mod     = '0;
                    st_d.wait_rs = 1'b1;
                    st_d.viol    = 1'b1;
                end
                SNP_INVAL: begin
                    st_d.valid = st_d.valid & ~snp_hit;
                    st_d.rd    = st_d.rd & ~snp_hit;
                    st_d.mod   = st_d.mod & ~snp_hit;
                end
                SNP_UPDATE: begin
                    st_d.upd     = 1'b1;
                    st_d.upd_idx = snp_idx;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_valid   = st_q.valid;
    assign line_rd      = st_q.rd;
    assign line_mod     = st_q.mod;
    assign violation    = st_q.viol;
    assign wait_restart = st_q.wait_rs;
    assign upd_en       = st_q.upd;
    assign upd_idx      = st_q.upd_idx;

endmodule

// File: rtl/slt_tracker_chk.sv
module slt_tracker_chk #(
    parameter int NUM_LINES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fill_en,
    input logic                 grant_held,
    input logic                 commit_done,
    input logic                 snp_en,
    input logic                 snp_has_data,
    input logic [NUM_LINES-1:0] line_valid,
    input logic [NUM_LINES-1:0] line_rd,
    input logic [NUM_LINES-1:0] line_mod,
    input logic                 violation,
    input logic                 wait_restart,
    input logic                 upd_en
);

    p_rd_on_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_rd & ~line_valid) == '0);

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> !violation);

    p_viol_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> $past(snp_en && !grant_held));

    p_viol_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> (line_rd == '0) && (line_mod == '0) && wait_restart);

    p_viol_drops_mod_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (violation && !$past(fill_en)) |-> ((line_valid & $past(line_mod)) == '0));

    p_upd_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> $past(snp_en && snp_has_data));

    p_commit_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_done && !wait_restart) |=> (line_rd == '0) && (line_mod == '0));

    p_grant_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_en && grant_held) |=> (!violation && !upd_en));

    p_wait_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wait_restart |=> (!violation && !upd_en));

endmodule

bind slt_tracker slt_tracker_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_en      (fill_en),
    .grant_held   (grant_held),
    .commit_done  (commit_done),
    .snp_en       (snp_en),
    .snp_has_data (snp_has_data),
    .line_valid   (line_valid),
    .line_rd      (line_rd),
    .line_mod     (line_mod),
    .violation    (violation),
    .wait_restart (wait_restart),
    .upd_en       (upd_en)
);

// File: tb/sim_slt_tracker.sv
`timescale 1ns/1ps
module sim_slt_tracker;

    localparam int NL = 4;
    localparam int AW = 8;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fill_en = 1'b0;
    logic [IW-1:0] fill_idx = '0;
    logic [AW-1:0] fill_addr = '0;
    logic          acc_en = 1'b0;
    logic          acc_wr = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          grant_held = 1'b0;
    logic          commit_done = 1'b0;
    logic          restart = 1'b0;
    logic          snp_en = 1'b0;
    logic          snp_has_data = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic [NL-1:0] line_valid, line_rd, line_mod;
    logic          violation, wait_restart, upd_en;
    logic [IW-1:0] upd_idx;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [NL-1:0] valid;
        logic [NL-1:0] rd;
        logic [NL-1:0] mod;
        logic          viol;
        logic          wt;
        logic          upd;
        logic [IW-1:0] uidx;
        string         req;
    } exp_t;

    exp_t q_exp[$];

    always #2.5 clk = ~clk;

    slt_tracker #(.NUM_LINES(NL), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_addr(fill_addr),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .grant_held(grant_held), .commit_done(commit_done), .restart(restart),
        .snp_en(snp_en), .snp_has_data(snp_has_data), .snp_addr(snp_addr),
        .line_valid(line_valid), .line_rd(line_rd), .line_mod(line_mod),
        .violation(violation), .wait_restart(wait_restart),
        .upd_en(upd_en), .upd_idx(upd_idx)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (line_valid !== e.valid || line_rd !== e.rd || line_mod !== e.mod ||
            violation !== e.viol || wait_restart !== e.wt || upd_en !== e.upd ||
            (e.upd && upd_idx !== e.uidx)) begin
            failures++;
            $display("FAIL %s: got v=%b r=%b m=%b viol=%b wait=%b upd=%b idx=%0d exp v=%b r=%b m=%b viol=%b wait=%b upd=%b idx=%0d",
                     e.req, line_valid, line_rd, line_mod, violation, wait_restart, upd_en, upd_idx,
                     e.valid, e.rd, e.mod, e.viol, e.wt, e.upd, e.uidx);
        end
    endtask

    // Monitor: each result appears one edge after its stimulus.
    always @(posedge clk) begin
        #1;
        if (q_exp.size() > 0) begin
            compare(q_exp.pop_front());
        end
    end

    task automatic cyc();
        @(negedge clk);
        fill_en = 0; acc_en = 0; acc_wr = 0; grant_held = 0;
        commit_done = 0; restart = 0; snp_en = 0; snp_has_data = 0;
    endtask

    task automatic expect_st(input logic [NL-1:0] v, input logic [NL-1:0] r,
                             input logic [NL-1:0] m, input logic vi, input logic w,
                             input logic u, input logic [IW-1:0] ui, input string req);
        exp_t e;
        e.valid = v; e.rd = r; e.mod = m; e.viol = vi; e.wt = w;
        e.upd = u; e.uidx = ui; e.req = req;
        q_exp.push_back(e);
    endtask

    task automatic do_fill(input logic [IW-1:0] i, input logic [AW-1:0] a);
        fill_en = 1; fill_idx = i; fill_addr = a;
    endtask

    task automatic do_acc(input logic wr, input logic [AW-1:0] a);
        acc_en = 1; acc_wr = wr; acc_addr = a;
    endtask

    task automatic do_snp(input logic dat, input logic [AW-1:0] a);
        snp_en = 1; snp_has_data = dat; snp_addr = a;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog: got no finish, expected finish before limit");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        exp_t e0;
        repeat (3) @(negedge clk);
        e0.valid = '0; e0.rd = '0; e0.mod = '0; e0.viol = 0; e0.wt = 0;
        e0.upd = 0; e0.uidx = '0; e0.req = "R1 reset";
        compare(e0);
        rst_n = 1;

        cyc(); do_fill(0, 8'h10); expect_st(4'b0001, 0, 0, 0, 0, 0, 0, "R2 fill0");
        cyc(); do_fill(1, 8'h20); expect_st(4'b0011, 0, 0, 0, 0, 0, 0, "R2 fill1");
        cyc(); do_fill(2, 8'h30); expect_st(4'b0111, 0, 0, 0, 0, 0, 0, "R2 fill2");
        cyc(); do_fill(3, 8'h40); expect_st(4'b1111, 0, 0, 0, 0, 0, 0, "R2 fill3");
        cyc(); do_acc(0, 8'h10);  expect_st(4'b1111, 4'b0001, 0, 0, 0, 0, 0, "R3 load");
        cyc(); do_acc(1, 8'h20);  expect_st(4'b1111, 4'b0001, 4'b0010, 0, 0, 0, 0, "R4 store");
        cyc(); do_acc(0, 8'h77);  expect_st(4'b1111, 4'b0001, 4'b0010, 0, 0, 0, 0, "R3 load miss");
        cyc(); do_snp(0, 8'h55);  expect_st(4'b1111, 4'b0001, 4'b0010, 0, 0, 0, 0, "R12 snoop miss");
        cyc(); do_snp(0, 8'h40);  expect_st(4'b0111, 4'b0001, 4'b0010, 0, 0, 0, 0, "R7 addr-only inval");
        cyc(); do_snp(1, 8'h30);  expect_st(4'b0111, 4'b0001, 4'b0010, 0, 0, 1, 2, "R8 update");
        cyc(); grant_held = 1; do_snp(0, 8'h10);
                                  expect_st(4'b0111, 4'b0001, 4'b0010, 0, 0, 0, 0, "R10 grant held");
        cyc(); do_snp(0, 8'h10);  expect_st(4'b0101, 0, 0, 1, 1, 0, 0, "R5 R6 violation");
        cyc();                    expect_st(4'b0101, 0, 0, 0, 1, 0, 0, "R5 single pulse");
        cyc(); do_acc(0, 8'h10);  expect_st(4'b0101, 0, 0, 0, 1, 0, 0, "R11 load ignored");
        cyc(); do_snp(0, 8'h30);  expect_st(4'b0101, 0, 0, 0, 1, 0, 0, "R11 snoop ignored");
        cyc(); restart = 1;       expect_st(4'b0101, 0, 0, 0, 0, 0, 0, "R11 restart");
        cyc(); do_fill(1, 8'h20); expect_st(4'b0111, 0, 0, 0, 0, 0, 0, "R2 refill");
        cyc(); do_acc(0, 8'h30);  expect_st(4'b0111, 4'b0100, 0, 0, 0, 0, 0, "R3 load2");
        cyc(); do_acc(1, 8'h20);  expect_st(4'b0111, 4'b0100, 4'b0010, 0, 0, 0, 0, "R4 store2");
        cyc(); commit_done = 1;   expect_st(4'b0111, 0, 0, 0, 0, 0, 0, "R9 commit");
        cyc(); do_snp(0, 8'h30);  expect_st(4'b0011, 0, 0, 0, 0, 0, 0, "R9 R7 post-commit inval");
        cyc(); do_snp(1, 8'h20);  expect_st(4'b0011, 0, 0, 0, 0, 1, 1, "R8 update line1");
        cyc();                    expect_st(4'b0011, 0, 0, 0, 0, 0, 0, "R8 update pulse ends");
        cyc(); cyc(); cyc();
        if (q_exp.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: got %0d unchecked, expected 0", q_exp.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule